// File: doc/BRIEF.md
# Glitch-Free Crystal/PLL System Clock Selector

This block picks the source of the system clock. Two candidates are offered: a crystal reference clock and the output of a PLL. After reset the crystal drives the system clock. The host moves the system clock to the PLL by setting a select bit through a simple register-write port, and it moves it back by clearing that bit.

A move to the PLL is allowed only once the PLL has had time to settle. The block counts frame-sync pulses after each write to the PLL programming register, and it holds back a select request until the second pulse has been seen. If the PLL or the front end is powered down, the block clears the select bit and returns to the crystal on its own.

The changeover is break-before-make. The running clock is stopped while low, and only after that is the new clock enabled, also while low. No shortened pulse reaches the output. A registered status flag, in the crystal domain, reports which source is driving the output.

Top module: `clk_source_switch`

## Requirements
- R1: While reset is held, and after it is released, the output clock follows the crystal input (high phase equal to the crystal high phase) and `pll_active` is 0.
- R2: A write to address 0x0E with data bit 7 = 1 sets the select bit, and with bit 7 = 0 it clears the bit, which returns the output to the crystal. Writes to other addresses, and the other data bits, have no effect on the selection.
- R3: The PLL is never selected unless address 0x0D has been written since the last reset or power-down, and at least two `frame_sync` pulses have been seen since that write. With no 0x0D write, any number of pulses does not enable the switch.
- R4: A select request that arrives before the second pulse is held pending. It takes effect after the second pulse, with no further write.
- R5: A write to 0x0D while `pll_active` is 0 restarts the pulse count from zero.
- R6: A write to 0x0D while `pll_active` is 1 leaves the count unchanged. After the host clears and then sets the select bit again, the PLL is reselected with no new pulses.
- R7: When `pll_pd` or `fe_pd` is 1 for a cycle, the select bit and the pulse count are cleared and the output returns to the crystal. Setting the select bit again has no effect until a new 0x0D write and two pulses.
- R8: The two clock enables are never on together. The old source is gated off before the new one is gated on.
- R9: No high or low phase of `clk_sys` is shorter than the shorter half-period of the two input clocks.
- R10: `pll_active` changes within 20 crystal cycles of the event that allows a switch, and it shows the source that is driving `clk_sys`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | Crystal reference clock; also the clock of the register and control logic |
| clk_pll | input | 1 | PLL output clock |
| rst | input | 1 | Synchronous active-high reset (crystal domain) |
| wr_en | input | 1 | Register write strobe, one crystal cycle |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| frame_sync | input | 1 | Frame-sync pulse, one crystal cycle per frame |
| pll_pd | input | 1 | PLL power-down |
| fe_pd | input | 1 | Front-end power-down |
| clk_sys | output | 1 | Selected system clock |
| pll_active | output | 1 | 1 when the PLL drives `clk_sys` |

## Verification
A switch crosses both clock domains: one register for the request, the synchronizer and gate stage of the crystal branch, then those of the PLL branch, then the status synchronizer. `pll_active` therefore moves about ten crystal cycles after the enabling write or pulse.

The bench allows a window of 20 cycles for each expected change. Where the requirements say nothing may happen, it requires the flag to stay unchanged for 40 cycles, which is twice that window.

The bench identifies the source by the width of the most recent high phase of `clk_sys`. It reads that width only after the flag has settled. A monitor that is always running measures every phase of `clk_sys` and flags any phase narrower than the shorter input half-period.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  localparam int unsigned NUM_SRC  = 2;
  localparam int unsigned SRC_XTAL = 0;
  localparam int unsigned SRC_PLL  = 1;
endpackage

// File: rtl/clksw_bit_sync.sv
module clksw_bit_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RST_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/clksw_gate_branch.sv
// One source branch: synchronize "want and the other branch is off",
// then update the gate enable on the falling edge so it only moves
// while this clock is low.
module clksw_gate_branch #(
  parameter int unsigned STAGES = 2,
  parameter bit          EN_RST = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic want,
  input  logic other_en,
  output logic en
);
  logic go_s;

  clksw_bit_sync #(.STAGES(STAGES), .RST_VAL(EN_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (want & ~other_en),
    .q   (go_s)
  );

  always_ff @(negedge clk) begin
    if (rst) en <= EN_RST;
    else     en <= go_s;
  end
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl #(
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned PLL_ADDR      = 'h0D,
  parameter int unsigned SEL_ADDR      = 'h0E,
  parameter int unsigned SEL_BIT       = 7,
  parameter int unsigned FRAMES_NEEDED = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              frame_sync,
  input  logic              pd,
  input  logic              xtal_en,
  input  logic              pll_on,
  output logic              req_pll
);
  localparam int unsigned CNT_W = $clog2(FRAMES_NEEDED + 1);
  localparam logic [DATA_W-1:0] SEL_MASK = DATA_W'(1) << SEL_BIT;

  logic             sel_q;
  logic             armed_q;
  logic [CNT_W-1:0] fcnt_q;
  logic             pll_wr, sel_wr, frames_done, want, settled;
  logic             unused_bits;

  assign unused_bits = ^(wr_data & ~SEL_MASK);
  assign pll_wr      = wr_en && (wr_addr == ADDR_W'(PLL_ADDR));
  assign sel_wr      = wr_en && (wr_addr == ADDR_W'(SEL_ADDR));
  assign frames_done = armed_q && (fcnt_q == CNT_W'(FRAMES_NEEDED));
  assign want        = sel_q && frames_done && !pd;
  // A new request is taken only when the last changeover has completed.
  assign settled     = req_pll ? (pll_on && !xtal_en) : (xtal_en && !pll_on);

  always_ff @(posedge clk) begin
    if (rst || pd) begin
      sel_q   <= 1'b0;
      armed_q <= 1'b0;
      fcnt_q  <= '0;
    end else begin
      if (sel_wr) sel_q <= wr_data[SEL_BIT];
      if (pll_wr && !pll_on) begin
        armed_q <= 1'b1;
        fcnt_q  <= '0;
      end else if (frame_sync && armed_q && !frames_done) begin
        fcnt_q  <= fcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          req_pll <= 1'b0;
    else if (settled) req_pll <= want;
  end

  assert_frame_gate_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(req_pll) |-> $past(frames_done));

  assert_pd_clears_R7: assert property (@(posedge clk) disable iff (rst)
    pd |=> !sel_q);

  assert_clear_bit_R2: assert property (@(posedge clk) disable iff (rst)
    (sel_wr && !wr_data[SEL_BIT] && !pd) |=> !sel_q);
endmodule

// File: rtl/clk_source_switch.sv
module clk_source_switch
  import clksw_pkg::*;
#(
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned PLL_ADDR      = 'h0D,
  parameter int unsigned SEL_ADDR      = 'h0E,
  parameter int unsigned SEL_BIT       = 7,
  parameter int unsigned FRAMES_NEEDED = 2,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic              clk_xtal,
  input  logic              clk_pll,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              frame_sync,
  input  logic              pll_pd,
  input  logic              fe_pd,
  output logic              clk_sys,
  output logic              pll_active
);
  logic               rst_pll;
  logic               req_pll;
  logic [NUM_SRC-1:0] src_clk, src_rst, src_want, src_en;

  clksw_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rst_pll (
    .clk (clk_pll),
    .rst (1'b0),
    .d   (rst),
    .q   (rst_pll)
  );

  clksw_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PLL_ADDR(PLL_ADDR),
    .SEL_ADDR(SEL_ADDR), .SEL_BIT(SEL_BIT), .FRAMES_NEEDED(FRAMES_NEEDED)
  ) u_ctrl (
    .clk        (clk_xtal),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .frame_sync (frame_sync),
    .pd         (pll_pd | fe_pd),
    .xtal_en    (src_en[SRC_XTAL]),
    .pll_on     (pll_active),
    .req_pll    (req_pll)
  );

  assign src_clk[SRC_XTAL]  = clk_xtal;
  assign src_clk[SRC_PLL]   = clk_pll;
  assign src_rst[SRC_XTAL]  = rst;
  assign src_rst[SRC_PLL]   = rst_pll;
  assign src_want[SRC_XTAL] = ~req_pll;
  assign src_want[SRC_PLL]  = req_pll;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_branch
    clksw_gate_branch #(
      .STAGES (SYNC_STAGES),
      .EN_RST (g == SRC_XTAL)
    ) u_br (
      .clk      (src_clk[g]),
      .rst      (src_rst[g]),
      .want     (src_want[g]),
      .other_en (src_en[NUM_SRC-1-g]),
      .en       (src_en[g])
    );
  end

  clksw_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_status (
    .clk (clk_xtal),
    .rst (rst),
    .d   (src_en[SRC_PLL]),
    .q   (pll_active)
  );

  assign clk_sys = |(src_clk & src_en);

  always @(posedge clk_xtal) begin
    if (!rst) begin
      assert_mutex_xtal_R8: assert (!(src_en[SRC_XTAL] && src_en[SRC_PLL]))
        else $error("both clock enables on");
    end
  end

  always @(posedge clk_pll) begin
    if (!rst_pll) begin
      assert_mutex_pll_R8: assert (!(src_en[SRC_XTAL] && src_en[SRC_PLL]))
        else $error("both clock enables on");
    end
  end
endmodule

// File: tb/sim_clk_source_switch.sv
module sim_clk_source_switch;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       clk_pll = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       frame_sync = 1'b0;
  logic       pll_pd = 1'b0;
  logic       fe_pd = 1'b0;
  logic       clk_sys, pll_active;

  int n_run = 0;
  int n_fail = 0;
  bit mon_on = 1'b0;
  int n_glitch = 0;
  realtime t_rise = 0.0, t_fall = 0.0, hi_w = 0.0;

  always #4 clk = ~clk;                 // 125 MHz crystal
  initial begin #1; forever #3 clk_pll = ~clk_pll; end

  clk_source_switch u0 (
    .clk_xtal(clk), .clk_pll(clk_pll), .rst(rst), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .frame_sync(frame_sync),
    .pll_pd(pll_pd), .fe_pd(fe_pd), .clk_sys(clk_sys), .pll_active(pll_active)
  );

  always @(posedge clk_sys) begin
    if (mon_on && ($realtime - t_fall) < 2.9) n_glitch++;
    t_rise = $realtime;
  end
  always @(negedge clk_sys) begin
    hi_w = $realtime - t_rise;
    if (mon_on && hi_w < 2.9) n_glitch++;
    t_fall = $realtime;
  end

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic fs_pulse();
    @(negedge clk); frame_sync = 1'b1;
    @(negedge clk); frame_sync = 1'b0;
  endtask

  task automatic wait_flag(string req, bit exp);
    int seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pll_active == exp) begin seen = 1; break; end
    end
    check(req, int'(pll_active), int'(exp));
    if (seen == 0) return;
  endtask

  task automatic hold_flag(string req, bit exp);
    int moved = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pll_active != exp) moved = 1;
    end
    check(req, moved, 0);
  endtask

  task automatic check_source(string req, bit pll);
    repeat (4) @(negedge clk);
    check(req, int'(hi_w * 1000.0), pll ? 3000 : 4000);
  endtask

  task automatic t_reset();
    check("R1 flag during reset", int'(pll_active), 0);
    check_source("R1 crystal during reset", 1'b0);
    @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);
    mon_on = 1'b1;
    check("R1 flag after reset", int'(pll_active), 0);
    check_source("R1 crystal after reset", 1'b0);
  endtask

  task automatic t_no_arm();
    reg_write(8'h0E, 8'h80);
    fs_pulse(); fs_pulse(); fs_pulse();
    hold_flag("R3 no switch without 0x0D write", 1'b0);
  endtask

  task automatic t_gate();
    reg_write(8'h0D, 8'h21);            // select bit already pending (R4)
    hold_flag("R3 zero frames", 1'b0);
    fs_pulse();
    hold_flag("R3 one frame", 1'b0);
    fs_pulse();
    wait_flag("R4 pending request applied", 1'b1);
    check_source("R10 PLL drives output", 1'b1);
  endtask

  task automatic t_back();
    reg_write(8'h0E, 8'h00);
    wait_flag("R2 clear returns to crystal", 1'b0);
    check_source("R10 crystal drives output", 1'b0);
  endtask

  task automatic t_ignored();
    reg_write(8'h0F, 8'h80);
    hold_flag("R2 other address ignored", 1'b0);
    reg_write(8'h0E, 8'h7F);
    hold_flag("R2 other bits ignored", 1'b0);
    reg_write(8'h0E, 8'h80);
    wait_flag("R2 bit 7 selects PLL", 1'b1);
  endtask

  task automatic t_write_while_pll();
    reg_write(8'h0D, 8'h33);
    reg_write(8'h0E, 8'h00);
    wait_flag("R6 clear", 1'b0);
    reg_write(8'h0E, 8'h80);
    wait_flag("R6 count kept", 1'b1);
  endtask

  task automatic t_restart();
    reg_write(8'h0E, 8'h00);
    wait_flag("R5 clear", 1'b0);
    reg_write(8'h0D, 8'h10);
    fs_pulse();
    reg_write(8'h0D, 8'h11);
    fs_pulse();
    reg_write(8'h0E, 8'h80);
    hold_flag("R5 count restarted", 1'b0);
    fs_pulse();
    wait_flag("R5 second frame after restart", 1'b1);
  endtask

  task automatic t_pd();
    @(negedge clk); pll_pd = 1'b1;
    @(negedge clk); pll_pd = 1'b0;
    wait_flag("R7 PLL power-down falls back", 1'b0);
    check_source("R7 crystal after power-down", 1'b0);
    hold_flag("R7 select bit cleared", 1'b0);
    reg_write(8'h0E, 8'h80);
    hold_flag("R7 count cleared", 1'b0);
    reg_write(8'h0D, 8'h12);
    fs_pulse(); fs_pulse();
    wait_flag("R7 rearmed", 1'b1);
    @(negedge clk); fe_pd = 1'b1;
    wait_flag("R7 front-end power-down falls back", 1'b0);
    @(negedge clk); fe_pd = 1'b0;
    hold_flag("R7 stays on crystal", 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog R10 actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    t_reset();
    t_no_arm();
    t_gate();
    t_back();
    t_ignored();
    t_write_while_pll();
    t_restart();
    t_pd();
    check("R8 R9 short phases on clk_sys", n_glitch, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule